// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Locked Ownership

This block decides which of several agents, for example four processor cores, may use a shared memory bus. An agent raises its request and is given a one-hot grant. It keeps that grant until it reports the end of its reference with a done pulse. Agents that do not ask for a lock get one reference per grant. The agents take turns in rotating order, so every requester is eventually served and none can starve the others.

An agent can also ask for exclusive ownership across several references by holding its lock input high. An atomic read-then-conditional-write sequence such as compare-exchange is the typical use. While the lock is held, done pulses from the owner do not release the bus. Every other agent waits, whatever address it wants. The grant ends only on a done pulse taken while the owner's lock is low. The rotation pointer then moves to the agent after the one that just released. A bus-owner output gives the index of the agent that currently holds the grant.

Top module: `lock_rr_arbiter`

## Requirements
- R1: After reset, gnt_o is all zero, owner_o is 0 and the rotation pointer is agent 0: the first grant with every agent requesting goes to agent 0.
- R2: gnt_o is one-hot or all zero in every cycle.
- R3: When no grant is active and at least one req_i bit is set, the grant appears on the next clock edge. It goes to the first requesting agent found by scanning upward from the pointer, wrapping from agent N_AGENTS-1 to agent 0.
- R4: An owner with lock low loses its grant on the edge at which its done bit is sampled high, so gnt_o is all zero in the following cycle.
- R5: While the owner keeps its lock bit high, its grant holds and no other agent is granted, even if the owner pulses done.
- R6: A locked grant ends on the edge at which the owner's done bit is sampled high while its lock bit is low.
- R7: When a grant ends, the pointer moves to the agent numbered one above the last owner, wrapping from N_AGENTS-1 to 0.
- R8: done_i bits of agents other than the current owner, and done_i while no grant is active, have no effect.
- R9: With no request pending and no grant active, gnt_o stays zero and the pointer keeps its value.
- R10: owner_o gives the index of the granted agent, where bit k of gnt_o is agent k, and owner_o is 0 while no grant is active.
- R11: After a grant ends, gnt_o is zero for exactly one cycle before the next grant, if requests are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_AGENTS | Per-agent bus request |
| lock_i | input | N_AGENTS | Per-agent exclusive-ownership request |
| done_i | input | N_AGENTS | Per-agent end-of-reference pulse |
| gnt_o | output | N_AGENTS | One-hot bus grant |
| owner_o | output | $clog2(N_AGENTS) | Index of the granted agent |

## Verification
The properties take for granted only that req_i, lock_i and done_i are synchronous to clk_i and stable around the edge. They put no protocol on the agents. A done from a non-owner and a lock raised without a grant are both legal and must be ignored. The stimulus changes inputs only on the falling edge. The random phase drives any mix of requests, locks and done pulses, with lock bits toggled rarely so that locked sequences last several references. Directed sequences force the reset pointer, the wrap from the last agent to the first, a long locked hold with repeated done pulses, and done pulses from agents that do not own the bus.

// File: rtl/lock_arb_pkg.sv
package lock_arb_pkg;
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/lock_arb_pick.sv
// Rotating-priority search: first requester at or above ptr_i, wrapping.
module lock_arb_pick #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDXW     = 2
) (
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [IDXW-1:0]     ptr_i,
  output logic                found_o,
  output logic [IDXW-1:0]     idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    // descending scan: the smallest offset is written last and wins
    for (int k = N_AGENTS - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_i) + k) % N_AGENTS]) begin
        found_o = 1'b1;
        idx_o   = IDXW'((int'(ptr_i) + k) % N_AGENTS);
      end
    end
  end
endmodule

// File: rtl/lock_arb_ctrl.sv
module lock_arb_ctrl
  import lock_arb_pkg::*;
#(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDXW     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] lock_i,
  input  logic [N_AGENTS-1:0] done_i,
  input  logic                pick_found_i,
  input  logic [IDXW-1:0]     pick_idx_i,
  output logic [IDXW-1:0]     ptr_o,
  output logic                owned_o,
  output logic [IDXW-1:0]     owner_o
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N_AGENTS - 1);

  arb_state_e      state_q;
  logic [IDXW-1:0] owner_q, ptr_q;
  logic            release_w;

  // only the owner's done counts, and only with its lock dropped
  assign release_w = done_i[owner_q] && !lock_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (pick_found_i) begin
            state_q <= ARB_OWNED;
            owner_q <= pick_idx_i;
          end
        end
        ARB_OWNED: begin
          if (release_w) begin
            state_q <= ARB_IDLE;
            ptr_q   <= (owner_q == LAST_IDX) ? '0 : owner_q + 1'b1;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign ptr_o   = ptr_q;
  assign owned_o = (state_q == ARB_OWNED);
  assign owner_o = owned_o ? owner_q : '0;
endmodule

// File: rtl/lock_arb_decode.sv
module lock_arb_decode #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDXW     = 2
) (
  input  logic                valid_i,
  input  logic [IDXW-1:0]     idx_i,
  output logic [N_AGENTS-1:0] onehot_o
);
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_dec
    assign onehot_o[g] = valid_i && (idx_i == IDXW'(g));
  end
endmodule

// File: rtl/lock_rr_arbiter.sv
module lock_rr_arbiter #(
  parameter int unsigned N_AGENTS = 4,
  localparam int unsigned IDXW    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [N_AGENTS-1:0] lock_i,
  input  logic [N_AGENTS-1:0] done_i,
  output logic [N_AGENTS-1:0] gnt_o,
  output logic [IDXW-1:0]     owner_o
);
  logic [IDXW-1:0] ptr_w, pick_idx_w, owner_w;
  logic            pick_found_w, owned_w;

  lock_arb_pick #(.N_AGENTS(N_AGENTS), .IDXW(IDXW)) i_pick (
    .req_i   (req_i),
    .ptr_i   (ptr_w),
    .found_o (pick_found_w),
    .idx_o   (pick_idx_w)
  );

  lock_arb_ctrl #(.N_AGENTS(N_AGENTS), .IDXW(IDXW)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_i       (lock_i),
    .done_i       (done_i),
    .pick_found_i (pick_found_w),
    .pick_idx_i   (pick_idx_w),
    .ptr_o        (ptr_w),
    .owned_o      (owned_w),
    .owner_o      (owner_w)
  );

  lock_arb_decode #(.N_AGENTS(N_AGENTS), .IDXW(IDXW)) i_dec (
    .valid_i  (owned_w),
    .idx_i    (owner_w),
    .onehot_o (gnt_o)
  );

  assign owner_o = owner_w;
endmodule

// File: rtl/lock_arb_chk.sv
module lock_arb_chk #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned IDXW     = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_AGENTS-1:0] req_i,
  input logic [N_AGENTS-1:0] lock_i,
  input logic [N_AGENTS-1:0] done_i,
  input logic [N_AGENTS-1:0] gnt_o,
  input logic [IDXW-1:0]     owner_o
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R3
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0));

  // R3
  grant_to_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|gnt_o) |-> ((gnt_o & $past(req_i)) != '0));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && done_i[owner_o] && !lock_i[owner_o]) |=> (gnt_o == '0));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !(done_i[owner_o] && !lock_i[owner_o])) |=> $stable(gnt_o));

  // R9
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0));

  // R10
  owner_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> gnt_o[owner_o]);

  // R10
  owner_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |-> (owner_o == '0));
endmodule

bind lock_rr_arbiter lock_arb_chk #(.N_AGENTS(N_AGENTS), .IDXW(IDXW)) i_lock_arb_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .lock_i  (lock_i),
  .done_i  (done_i),
  .gnt_o   (gnt_o),
  .owner_o (owner_o)
);

// File: tb/test_lock_rr_arbiter.sv
`timescale 1ns/1ps
module test_lock_rr_arbiter;
  localparam int N    = 4;
  localparam int IDXW = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    req = '0, lock = '0, done = '0;
  logic [N-1:0]    gnt;
  logic [IDXW-1:0] owner;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  lock_rr_arbiter #(.N_AGENTS(N)) i_lock_rr_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .lock_i(lock), .done_i(done),
    .gnt_o(gnt), .owner_o(owner)
  );

  always #5 clk = ~clk;

  // reference state, from the requirements
  bit m_busy;
  int m_owner, m_ptr;

  function automatic int pick(logic [N-1:0] r, int p);
    for (int k = 0; k < N; k++) if (r[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; m_owner <= 0; m_ptr <= 0;
    end else if (m_busy) begin
      if (done[m_owner] && !lock[m_owner]) begin
        m_busy <= 1'b0;
        m_ptr  <= (m_owner + 1) % N;
      end
    end else if (req != '0) begin
      m_busy  <= 1'b1;
      m_owner <= pick(req, m_ptr);
    end
  end

  function automatic logic [N-1:0] exp_gnt();
    return m_busy ? (N'(1) << m_owner) : '0;
  endfunction

  task automatic check(string tag);
    logic [N-1:0] eg;
    int eo;
    eg = exp_gnt();
    eo = m_busy ? m_owner : 0;
    checks++;
    if (gnt !== eg || int'(owner) != eo) begin
      errors++;
      $display("FAIL %s gnt=%b owner=%0d expected gnt=%b owner=%0d", tag, gnt, owner, eg, eo);
    end
  endtask

  // sample at the falling edge, then drive the next inputs
  task automatic step(string tag, logic [N-1:0] r, logic [N-1:0] l, logic [N-1:0] d);
    @(negedge clk);
    check(tag);
    req = r; lock = l; done = d;
  endtask

  task automatic expect_grant(string tag, logic [N-1:0] g);
    checks++;
    if (gnt !== g) begin
      errors++;
      $display("FAIL %s gnt=%b expected %b", tag, gnt, g);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check("R1");
    expect_grant("R1", 4'b0000);
    rst_ni = 1'b1;
    // R9: idle, no requests
    step("R9", '0, '0, '0);
    step("R9", '0, '0, 4'b0110);
    step("R9", '0, '0, '0);
    // R1 / R3: all request, pointer still 0 -> agent 0
    step("R9", 4'b1111, '0, '0);
    step("R3", 4'b1111, '0, 4'b0100); expect_grant("R1", 4'b0001);
    // R8: done from agent 2 was just applied; grant holds
    step("R8", 4'b1111, '0, 4'b0001);
    expect_grant("R8", 4'b0001);
    step("R4", 4'b1110, '0, '0);
    expect_grant("R4", 4'b0000);
    // R11 / R7: next grant one cycle later, to agent 1
    step("R11", 4'b1110, '0, 4'b0010);
    expect_grant("R7", 4'b0010);
    step("R4", 4'b1100, 4'b0100, '0);
    expect_grant("R11", 4'b0000);
    // R5: agent 2 locked, done pulses ignored
    step("R5", 4'b1100, 4'b0100, 4'b0100);
    expect_grant("R5", 4'b0100);
    step("R5", 4'b1100, 4'b0100, 4'b1000);
    step("R5", 4'b1100, 4'b0100, 4'b0100);
    expect_grant("R5", 4'b0100);
    step("R5", 4'b1100, 4'b0000, '0);
    expect_grant("R5", 4'b0100);
    step("R6", 4'b1000, 4'b0000, 4'b0100);
    expect_grant("R6", 4'b0100);
    step("R6", 4'b1001, '0, '0);
    expect_grant("R6", 4'b0000);
    // R7: agent 3 next, then wrap to agent 0
    step("R7", 4'b1001, '0, 4'b1000);
    expect_grant("R7", 4'b1000);
    step("R7", 4'b1001, '0, '0);
    step("R7", 4'b1001, '0, '0);
    expect_grant("R7", 4'b0001);
    step("R4", '0, '0, 4'b0001);
    step("R9", '0, '0, '0);
    step("R9", '0, '0, '0);
    expect_grant("R9", 4'b0000);
    // R2 / R10: random traffic, locks toggled rarely
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] l;
      l = lock;
      if (($urandom % 8) == 0) l[$urandom % N] = ~l[$urandom % N];
      step("R2", N'($urandom), l, N'($urandom) & N'($urandom));
    end
    step("R10", '0, '0, '0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule